// File: doc/BRIEF.md
# Parallel ATA Host Programmed-I/O Register Access Engine

This block sits on the host side of a 40-pin parallel ATA cable. It performs one programmed-I/O register read or write at a time. A request names the register block (command or control), a 3-bit register index inside that block, the direction, a 16-bit write value and a width flag. The engine then runs a fixed bus cycle:

- It asserts exactly one active-low chip select and the address lines.
- After a setup time it pulses the active-low read or write strobe.
- It holds the strobe low for at least a minimum width, and longer while the device pulls IORDY low.
- It keeps the select and address for a hold time, then releases the bus.

On reads it captures the data bus when the strobe rises. It returns the captured value together with a one-cycle done pulse.

A single index can name different registers on read and on write. For example, index 7 of the command block is status on read and command on write, and index 6 of the control block is alternate status on read and device control on write. The engine does not decode register meaning, so both cases are handled by the direction flag. Narrow accesses, which are used for command and register traffic, place only bits 7:0 on the bus. Wide accesses, which are used for data-register transfers, use all 16 bits.

The controller is a four-state machine:

| State | Role | Transitions out |
|---|---|---|
| `ST_IDLE` | Bus released | `T_ACCEPT` to `ST_SETUP` when a request arrives |
| `ST_SETUP` | Select and address driven, strobe high | `T_SETUP_DONE` to `ST_STROBE` after `SETUP_CYC` cycles |
| `ST_STROBE` | Strobe low | `T_WAIT` stays while the minimum width is not yet met or the synchronized IORDY is low; `T_RELEASE` goes to `ST_HOLD` otherwise |
| `ST_HOLD` | Strobe high, select and address still driven | `T_HOLD_DONE` returns to `ST_IDLE` after `HOLD_CYC` cycles and raises done |

Top module: `pata_pio_engine`

## Requirements
- R1: While in reset and whenever idle, both chip selects and both strobes are high, the data output enable is low, busy is low, and the address output is 0.
- R2: During an access, a command-block request (`req_ctrl`=0) drives `ata_cs0_n` low and `ata_cs1_n` high. A control-block request (`req_ctrl`=1) drives `ata_cs1_n` low and `ata_cs0_n` high. The two are never low together, and `ata_addr` equals the requested index throughout the access.
- R3: Select and address are valid for exactly `SETUP_CYC` cycles before the strobe falls, and for exactly `HOLD_CYC` cycles after it rises. The strobe is low only while a chip select is low.
- R4: A write pulses only `ata_diow_n` low, and a read pulses only `ata_dior_n` low. The two strobes are never low together.
- R5: With IORDY high, the strobe stays low for exactly `STROBE_MIN` cycles. It is never low for fewer than `STROBE_MIN` cycles.
- R6: IORDY passes through a two-flop synchronizer. If IORDY is low before the strobe falls and rises during strobe-low cycle j (counting from 0), the strobe stays low for max(`STROBE_MIN`, j+3) cycles.
- R7: On a write, `ata_data_oe` is high from the first setup cycle through the last hold cycle. `ata_data_out` is `req_wdata` when `req_wide`=1, and {8'h00, `req_wdata`[7:0]} when `req_wide`=0. `ata_data_oe` is never high on a read.
- R8: On a read, `rdata` takes the value of `ata_data_in` in the last strobe-low cycle. A narrow read zeroes bits 15:8. `rdata` holds that value until the next read completes.
- R9: `busy` is high from the cycle after acceptance through the last hold cycle. `done` is high for exactly one cycle, in the following cycle, while `busy` is low.
- R10: A request presented while busy is ignored. The bus keeps the accepted request's select and address, and no further access starts once it is withdrawn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_ctrl | input | 1 | 0 selects the command block, 1 selects the control block |
| req_addr | input | 3 | Register index within the block |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wide | input | 1 | 1 for a 16-bit transfer, 0 for the low byte only |
| req_wdata | input | 16 | Write value |
| busy | output | 1 | Access in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read result |
| ata_cs0_n | output | 1 | Command-block select, active low |
| ata_cs1_n | output | 1 | Control-block select, active low |
| ata_addr | output | 3 | Register address lines |
| ata_dior_n | output | 1 | Read strobe, active low |
| ata_diow_n | output | 1 | Write strobe, active low |
| ata_data_out | output | 16 | Value driven onto the data bus |
| ata_data_oe | output | 1 | Data bus output enable for the pad tristate |
| ata_data_in | input | 16 | Value sampled from the data bus |
| ata_iordy | input | 1 | Device ready; low inserts wait states |

## Verification
Random accesses mix both blocks, all eight indices, both directions and both widths. This exposes swapped selects, a wrong strobe, or lost upper-byte masking. The read data on the bus changes in every strobe cycle, so `rdata` shows exactly which cycle was sampled. Accesses with IORDY held low and released at cycles 0 through 7 separate a missing stretch, a wrong synchronizer depth, and a lost minimum width. Directed cases cover status read and command write at command index 7, alternate-status read and device-control write at control index 6, and a request held through a busy access, which shows whether a second access is started.

// File: rtl/pata_pio_pkg.sv
package pata_pio_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } pio_state_e;

    typedef struct packed {
        logic        ctrl_blk;
        logic [2:0]  reg_idx;
        logic        is_write;
        logic        is_wide;
        logic [15:0] wdata;
    } pio_req_t;

endpackage

// File: rtl/pata_iordy_sync.sv
module pata_iordy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain[i] <= 1'b1;
                end else if (i == 0) begin
                    chain[i] <= async_in;
                end else begin
                    chain[i] <= chain[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pata_phase_timer.sv
module pata_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pata_pio_fsm.sv
module pata_pio_fsm
    import pata_pio_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_MIN = 4,
    parameter int HOLD_CYC   = 2,
    parameter int CNT_W      = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             iordy_ok,
    input  logic [CNT_W-1:0] phase_cnt,
    output pio_state_e       state,
    output logic             accept,
    output logic             release_pulse,
    output logic             timer_clr,
    output logic             busy,
    output logic             done
);
    localparam logic [CNT_W-1:0] SETUP_LAST  = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0] STROBE_LAST = CNT_W'(STROBE_MIN - 1);
    localparam logic [CNT_W-1:0] HOLD_LAST   = CNT_W'(HOLD_CYC - 1);

    pio_state_e state_q, state_d;
    logic       finish;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            done    <= finish;
        end
    end

    // transitions and outputs
    always_comb begin
        state_d       = state_q;
        accept        = 1'b0;
        release_pulse = 1'b0;
        finish        = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin            // T_ACCEPT
                    state_d = ST_SETUP;
                    accept  = 1'b1;
                end
            end
            ST_SETUP: begin
                if (phase_cnt == SETUP_LAST) begin  // T_SETUP_DONE
                    state_d = ST_STROBE;
                end
            end
            ST_STROBE: begin
                if (phase_cnt >= STROBE_LAST && iordy_ok) begin // T_RELEASE
                    state_d       = ST_HOLD;
                    release_pulse = 1'b1;
                end                              // else T_WAIT
            end
            ST_HOLD: begin
                if (phase_cnt == HOLD_LAST) begin   // T_HOLD_DONE
                    state_d = ST_IDLE;
                    finish  = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        timer_clr = (state_d != state_q);
        busy      = (state_q != ST_IDLE);
    end

    assign state = state_q;
endmodule

// File: rtl/pata_bus_datapath.sv
module pata_bus_datapath
    import pata_pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  pio_state_e  state,
    input  logic        accept,
    input  logic        release_pulse,
    input  pio_req_t    req_in,
    input  logic [15:0] bus_in,
    output logic        cs0_n,
    output logic        cs1_n,
    output logic [2:0]  addr,
    output logic        dior_n,
    output logic        diow_n,
    output logic [15:0] bus_out,
    output logic        bus_oe,
    output logic [15:0] rdata
);
    pio_req_t cur;
    logic     active;
    logic     strobe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur   <= '0;
            rdata <= '0;
        end else begin
            if (accept) begin
                cur <= req_in;
            end
            if (release_pulse && !cur.is_write) begin
                rdata <= cur.is_wide ? bus_in : {8'h00, bus_in[7:0]};
            end
        end
    end

    always_comb begin
        active  = (state != ST_IDLE);
        strobe  = (state == ST_STROBE);
        cs0_n   = !(active && !cur.ctrl_blk);
        cs1_n   = !(active && cur.ctrl_blk);
        addr    = active ? cur.reg_idx : 3'd0;
        dior_n  = !(strobe && !cur.is_write);
        diow_n  = !(strobe && cur.is_write);
        bus_oe  = active && cur.is_write;
        bus_out = '0;
        if (bus_oe) begin
            bus_out = cur.is_wide ? cur.wdata : {8'h00, cur.wdata[7:0]};
        end
    end
endmodule

// File: rtl/pata_pio_engine.sv
module pata_pio_engine
    import pata_pio_pkg::*;
#(
    parameter int SETUP_CYC  = 2,
    parameter int STROBE_MIN = 4,
    parameter int HOLD_CYC   = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_ctrl,
    input  logic [2:0]  req_addr,
    input  logic        req_write,
    input  logic        req_wide,
    input  logic [15:0] req_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        ata_cs0_n,
    output logic        ata_cs1_n,
    output logic [2:0]  ata_addr,
    output logic        ata_dior_n,
    output logic        ata_diow_n,
    output logic [15:0] ata_data_out,
    output logic        ata_data_oe,
    input  logic [15:0] ata_data_in,
    input  logic        ata_iordy
);
    localparam int MAX_A   = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int MAX_CYC = (MAX_A > STROBE_MIN) ? MAX_A : STROBE_MIN;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    pio_state_e       state;
    pio_req_t         req_in;
    logic             accept;
    logic             release_pulse;
    logic             timer_clr;
    logic             iordy_s;
    logic [CNT_W-1:0] phase_cnt;

    assign req_in = '{ctrl_blk: req_ctrl, reg_idx: req_addr, is_write: req_write,
                      is_wide: req_wide, wdata: req_wdata};

    pata_iordy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ata_iordy),
        .sync_out (iordy_s)
    );

    pata_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (timer_clr),
        .cnt   (phase_cnt)
    );

    pata_pio_fsm #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_MIN (STROBE_MIN),
        .HOLD_CYC   (HOLD_CYC),
        .CNT_W      (CNT_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .iordy_ok      (iordy_s),
        .phase_cnt     (phase_cnt),
        .state         (state),
        .accept        (accept),
        .release_pulse (release_pulse),
        .timer_clr     (timer_clr),
        .busy          (busy),
        .done          (done)
    );

    pata_bus_datapath u_dp (
        .clk           (clk),
        .rst_n         (rst_n),
        .state         (state),
        .accept        (accept),
        .release_pulse (release_pulse),
        .req_in        (req_in),
        .bus_in        (ata_data_in),
        .cs0_n         (ata_cs0_n),
        .cs1_n         (ata_cs1_n),
        .addr          (ata_addr),
        .dior_n        (ata_dior_n),
        .diow_n        (ata_diow_n),
        .bus_out       (ata_data_out),
        .bus_oe        (ata_data_oe),
        .rdata         (rdata)
    );
endmodule

// File: rtl/pata_pio_checker.sv
module pata_pio_checker #(
    parameter int STROBE_MIN = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       cs0_n,
    input logic       cs1_n,
    input logic [2:0] addr,
    input logic       dior_n,
    input logic       diow_n,
    input logic       oe
);
    logic        strobe_hi;
    logic [15:0] low_cnt;

    assign strobe_hi = dior_n && diow_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_cnt <= '0;
        end else if (!strobe_hi) begin
            if (low_cnt != 16'hFFFF) low_cnt <= low_cnt + 1'b1;
        end else begin
            low_cnt <= '0;
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (cs0_n && cs1_n && strobe_hi && !oe));

    assert_cs_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(!cs0_n && !cs1_n));

    assert_strobe_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_hi |-> (busy && (!cs0_n || !cs1_n)));

    assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(!dior_n && !diow_n));

    assert_min_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_hi) |-> (low_cnt >= 16'(STROBE_MIN)));

    assert_no_drive_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> dior_n);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_select_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(addr) && $stable(cs0_n) && $stable(cs1_n)));
endmodule

bind pata_pio_engine pata_pio_checker #(.STROBE_MIN(STROBE_MIN)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .busy   (busy),
    .done   (done),
    .cs0_n  (ata_cs0_n),
    .cs1_n  (ata_cs1_n),
    .addr   (ata_addr),
    .dior_n (ata_dior_n),
    .diow_n (ata_diow_n),
    .oe     (ata_data_oe)
);

// File: tb/pata_pio_engine_bench.sv
module pata_pio_engine_bench;
    localparam int SETUP_CYC  = 2;
    localparam int STROBE_MIN = 4;
    localparam int HOLD_CYC   = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ctrl = 1'b0;
    logic [2:0]  req_addr = 3'd0;
    logic        req_write = 1'b0;
    logic        req_wide = 1'b0;
    logic [15:0] req_wdata = 16'h0;
    logic        busy, done;
    logic [15:0] rdata;
    logic        ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_data_oe;
    logic [2:0]  ata_addr;
    logic [15:0] ata_data_out;
    logic [15:0] ata_data_in = 16'h0;
    logic        ata_iordy = 1'b1;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    pata_pio_engine #(
        .SETUP_CYC  (SETUP_CYC),
        .STROBE_MIN (STROBE_MIN),
        .HOLD_CYC   (HOLD_CYC)
    ) u_pata_pio_engine (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ctrl (req_ctrl), .req_addr (req_addr),
        .req_write (req_write), .req_wide (req_wide), .req_wdata (req_wdata),
        .busy (busy), .done (done), .rdata (rdata),
        .ata_cs0_n (ata_cs0_n), .ata_cs1_n (ata_cs1_n), .ata_addr (ata_addr),
        .ata_dior_n (ata_dior_n), .ata_diow_n (ata_diow_n),
        .ata_data_out (ata_data_out), .ata_data_oe (ata_data_oe),
        .ata_data_in (ata_data_in), .ata_iordy (ata_iordy)
    );

    function automatic int exp_width(input bit stall, input int j);
        if (!stall) return STROBE_MIN;
        return (j + 3 > STROBE_MIN) ? j + 3 : STROBE_MIN;
    endfunction

    function automatic logic [15:0] exp_lane(input logic wide, input logic [15:0] v);
        return wide ? v : {8'h00, v[7:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic run_access(input logic ctrl, input logic [2:0] addr, input logic wr,
                              input logic wide, input logic [15:0] wdata,
                              input logic [15:0] base, input bit stall, input int j,
                              input bit intrude);
        int  setup_cnt = 0;
        int  width = 0;
        int  hold_cnt = 0;
        int  busy_cnt = 0;
        int  phase = 0;
        bit  cs_bad = 0, kind_bad = 0, oe_bad = 0, done_bad = 0, order_bad = 0;
        logic [15:0] last_in;
        @(negedge clk);
        ata_iordy   = stall ? 1'b0 : 1'b1;
        ata_data_in = base;
        req_ctrl = ctrl; req_addr = addr; req_write = wr; req_wide = wide;
        req_wdata = wdata; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        if (intrude) begin
            req_valid = 1'b1; req_ctrl = ~ctrl; req_addr = addr ^ 3'd5;
            req_write = ~wr;
        end
        for (int guard = 0; guard < 500; guard++) begin
            if (!busy) break;
            busy_cnt++;
            if (ata_cs0_n != ctrl || ata_cs1_n != !ctrl || ata_addr != addr) cs_bad = 1;
            if (done) done_bad = 1;
            if (ata_data_oe != wr) oe_bad = 1;
            if (wr && ata_data_out != exp_lane(wide, wdata)) oe_bad = 1;
            if (!ata_dior_n || !ata_diow_n) begin
                if (wr ? (ata_diow_n || !ata_dior_n) : (ata_dior_n || !ata_diow_n)) kind_bad = 1;
                if (phase == 2) order_bad = 1;
                phase = 1;
                width++;
                ata_data_in = base + 16'(width);
                if (stall && width == j + 1) ata_iordy = 1'b1;
            end else if (phase == 0) begin
                setup_cnt++;
            end else begin
                phase = 2;
                hold_cnt++;
                if (intrude) req_valid = 1'b0;
            end
            @(negedge clk);
        end
        last_in = base + 16'(exp_width(stall, j));
        chk(!cs_bad, "R2", "select/address during access", {ata_cs1_n, ata_cs0_n, 27'd0, ata_addr}, {!ctrl, ctrl, 27'd0, addr});
        chk(setup_cnt == SETUP_CYC, "R3", "setup cycles", setup_cnt, SETUP_CYC);
        chk(hold_cnt == HOLD_CYC && !order_bad, "R3", "hold cycles", hold_cnt, HOLD_CYC);
        chk(!kind_bad, "R4", "strobe kind", {ata_dior_n, ata_diow_n}, {wr, !wr});
        chk(width == exp_width(stall, j), stall ? "R6" : "R5", "strobe width", width, exp_width(stall, j));
        chk(!oe_bad, "R7", "write drive/data", ata_data_out, exp_lane(wide, wdata));
        chk(!done_bad && done && busy_cnt == SETUP_CYC + exp_width(stall, j) + HOLD_CYC,
            "R9", "busy span/done", busy_cnt, SETUP_CYC + exp_width(stall, j) + HOLD_CYC);
        if (!wr) chk(rdata == exp_lane(wide, last_in), "R8", "read data", rdata, exp_lane(wide, last_in));
        ata_iordy = 1'b1;
        if (intrude) begin
            bit idle_bad = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk);
                if (busy || !ata_cs0_n || !ata_cs1_n) idle_bad = 1;
            end
            chk(!idle_bad, "R10", "no access after busy-time request", busy, 0);
        end
    endtask

    initial begin
        logic [15:0] keep;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        chk(ata_cs0_n && ata_cs1_n && ata_dior_n && ata_diow_n && !ata_data_oe && !busy && !done,
            "R1", "reset state", {ata_cs0_n, ata_cs1_n, ata_dior_n, ata_diow_n, ata_data_oe, busy}, 6'b111100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(ata_cs0_n && ata_cs1_n && ata_addr == 3'd0 && !busy, "R1", "idle after reset",
            {ata_cs0_n, ata_cs1_n, 1'b0, ata_addr}, 6'b110000);
        // directed: status read / command write, alt status read / device control write
        run_access(1'b0, 3'd7, 1'b0, 1'b0, 16'h0, 16'hA550, 1'b0, 0, 1'b0);
        run_access(1'b0, 3'd7, 1'b1, 1'b0, 16'hBEA0, 16'h0, 1'b0, 0, 1'b0);
        run_access(1'b1, 3'd6, 1'b0, 1'b0, 16'h0, 16'h12F0, 1'b0, 0, 1'b0);
        run_access(1'b1, 3'd6, 1'b1, 1'b0, 16'h0304, 16'h0, 1'b0, 0, 1'b0);
        // wide data register read and write
        run_access(1'b0, 3'd0, 1'b0, 1'b1, 16'h0, 16'hC3F0, 1'b0, 0, 1'b0);
        run_access(1'b0, 3'd0, 1'b1, 1'b1, 16'h9A5C, 16'h0, 1'b0, 0, 1'b0);
        // IORDY stretch sweep
        for (int j = 0; j < 8; j++)
            run_access(1'b0, 3'd0, 1'b0, 1'b1, 16'h0, 16'h1000 * 16'(j), 1'b1, j, 1'b0);
        // R8: a write does not disturb the last read result
        keep = rdata;
        run_access(1'b1, 3'd6, 1'b1, 1'b1, 16'hFFFF, 16'h0, 1'b0, 0, 1'b0);
        chk(rdata == keep, "R8", "rdata held across write", rdata, keep);
        // R10: request held while busy
        run_access(1'b1, 3'd2, 1'b1, 1'b0, 16'h00E7, 16'h0, 1'b0, 0, 1'b1);
        // random mix
        for (int n = 0; n < 40; n++) begin
            bit st = ($urandom % 3) == 0;
            run_access(1'($urandom), 3'($urandom), 1'($urandom), 1'($urandom),
                       16'($urandom), 16'($urandom), st, int'($urandom % 8), 1'b0);
        end
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule